// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 64K words by 16 bits. The RAM has a lower and an upper byte lane. A host request names a word address, a direction, a byte-lane mask and the write data. The controller turns each request into a sequence of active-low memory strobes: chip select, output enable, write strobe and one lane strobe per byte. It holds each phase for a whole number of clock cycles. These counts are worked out at elaboration from the clock period and the nanosecond figures of the memory's speed grade.

The data bus is split into an output word, a drive-enable and an input word, so that the pad ring can build the bidirectional pins. Read data is captured in a register. Lanes the host did not ask for read back as zero. Every request completes with a one-cycle acknowledge. Between accesses chip select stays high, so the memory rests in its standby state.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low and `host_ack` is low. After reset all lane strobes are also high.
- R2: A read drives `mem_ce_n` and `mem_oe_n` low and holds `mem_we_n` high for RD_CYC+1 cycles (7 at the defaults). `mem_bn[i]` is low exactly when `host_be[i]` is 1. Lane 0 is data bits 7:0 and lane 1 is data bits 15:8. `host_rdata` returns the memory word sampled at the end, with the lanes not requested forced to zero.
- R3: A write holds `mem_ce_n` low and drives the lane strobes as in R2. It runs one setup cycle with `mem_we_n` high, then WP_CYC cycles with `mem_we_n` low (5 at the defaults), then one recovery cycle with `mem_we_n` high. `mem_dq_oe` is high over all three phases.
- R4: `mem_addr` and `mem_dq_o` are latched at acceptance and stay fixed until the access ends. Host-port changes after acceptance have no effect, and the address never moves while `mem_we_n` is low.
- R5: `host_ack` is high for exactly one cycle per request. With the defaults it rises 8 clock edges after `host_req` is first presented to an idle controller. This is RD_CYC+2 edges for a read and WP_CYC+3 edges for a write.
- R6: `mem_oe_n` is never low while `mem_dq_oe` is high. After a write, `mem_oe_n` stays high for at least TA_CYC cycles (3 at the defaults) with `mem_dq_oe` low before it falls again.
- R7: A request is taken only in the idle state, outside the acknowledge cycle and after the post-write guard. The host holds `host_req` high until it sees `host_ack`.
- R8: Each count is the ceiling of the nanosecond figure over the clock period, with a minimum of one cycle. The write-low phase also covers the data-setup figure and the cycle time minus its two framing cycles. The read phase covers the address and output-enable access times and the cycle time minus the capture cycle.
- R9: A write changes only the lanes whose `host_be` bit is 1. A write with mask 00 leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_be | input | 2 | Active-high byte-lane mask |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with acknowledge |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_bn | output | 2 | Lane strobes, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
A sequencer stuck in a read or write phase shows within a few cycles. It appears as an acknowledge that arrives at the wrong edge or never arrives, or as a write strobe whose low time is not exactly the computed count. A wrong lane latch or a missed capture shows on the very next read-back as a lane holding stale or filler data. A missing post-write guard shows in the first read after a write: output enable falls fewer than three cycles after the drive-enable drops, or while it is still high. The bench measures that window directly at the pins.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_CAP,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOV
  } asram_state_e;

  // cycles covering a nanosecond figure, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_wait_timer.sv
module asram_wait_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC = 6,
  parameter int WP_CYC = 5,
  parameter int TA_CYC = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic         req_we,
  output logic         accept,
  output asram_state_e nxt,
  output logic         capture,
  output logic         ack
);
  localparam int CW = $clog2(umax(umax(RD_CYC, WP_CYC), TA_CYC) + 1);

  asram_state_e  st;
  logic          ph_load, ph_zero, gd_load, gd_zero;
  logic [CW-1:0] ph_val;

  always_comb begin
    nxt     = st;
    accept  = 1'b0;
    ph_load = 1'b0;
    ph_val  = '0;
    gd_load = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req && !ack && gd_zero) begin
          accept = 1'b1;
          if (req_we) begin
            nxt = ST_WR_SETUP;
          end else begin
            nxt     = ST_RD_ACC;
            ph_load = 1'b1;
            ph_val  = CW'(RD_CYC - 1);
          end
        end
      end
      ST_RD_ACC:   if (ph_zero) nxt = ST_RD_CAP;
      ST_RD_CAP:   nxt = ST_IDLE;
      ST_WR_SETUP: begin
        nxt     = ST_WR_PULSE;
        ph_load = 1'b1;
        ph_val  = CW'(WP_CYC - 1);
      end
      ST_WR_PULSE: if (ph_zero) nxt = ST_WR_RECOV;
      ST_WR_RECOV: begin
        nxt     = ST_IDLE;
        gd_load = 1'b1;
      end
      default:     nxt = ST_IDLE;
    endcase
  end

  // phase length timer
  asram_wait_timer #(.CW(CW)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  // bus turnaround guard after a write
  asram_wait_timer #(.CW(CW)) u_guard (
    .clk(clk), .rst(rst), .load(gd_load), .load_val(CW'(TA_CYC - 1)), .zero(gd_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      ack <= 1'b0;
    end else begin
      st  <= nxt;
      ack <= (st == ST_RD_CAP) || (st == ST_WR_RECOV);
    end
  end

  assign capture = (st == ST_RD_CAP);
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  asram_state_e     nxt,
  input  logic             capture,
  input  logic [AW-1:0]    host_addr,
  input  logic [LANES-1:0] host_be,
  input  logic [DW-1:0]    host_wdata,
  input  logic [DW-1:0]    mem_dq_i,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_bn,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe,
  output logic [DW-1:0]    host_rdata
);
  logic [LANES-1:0] be_q, be_src;
  logic             nxt_act, nxt_rd, nxt_wr;

  assign nxt_act = (nxt != ST_IDLE);
  assign nxt_rd  = (nxt == ST_RD_ACC) || (nxt == ST_RD_CAP);
  assign nxt_wr  = (nxt == ST_WR_SETUP) || (nxt == ST_WR_PULSE) || (nxt == ST_WR_RECOV);
  assign be_src  = accept ? host_be : be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      be_q      <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr <= host_addr;
        mem_dq_o <= host_wdata;
        be_q     <= host_be;
      end
      mem_ce_n  <= !nxt_act;
      mem_oe_n  <= !nxt_rd;
      mem_we_n  <= (nxt != ST_WR_PULSE);
      mem_dq_oe <= nxt_wr;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        mem_bn[l]          <= 1'b1;
        host_rdata[l*8 +: 8] <= '0;
      end else begin
        mem_bn[l] <= !(nxt_act && be_src[l]);
        if (capture)
          host_rdata[l*8 +: 8] <= be_q[l] ? mem_dq_i[l*8 +: 8] : 8'h00;
      end
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW             = 16,
  parameter int DW             = 16,
  parameter int CLK_NS         = 10,
  parameter int T_CYCLE_NS     = 55,
  parameter int T_ACCESS_NS    = 55,
  parameter int T_OE_ACCESS_NS = 35,
  parameter int T_PULSE_NS     = 45,
  parameter int T_DSETUP_NS    = 25,
  parameter int T_TURN_NS      = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW/8-1:0]   host_be,
  input  logic [DW-1:0]     host_wdata,
  output logic              host_ack,
  output logic [DW-1:0]     host_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DW/8-1:0]   mem_bn,
  output logic [DW-1:0]     mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_dq_i
);
  localparam int LANES  = DW / 8;
  localparam int RD_CYC = umax(umax(ns_to_cyc(T_ACCESS_NS, CLK_NS), ns_to_cyc(T_OE_ACCESS_NS, CLK_NS)),
                               umax(ns_to_cyc(T_CYCLE_NS, CLK_NS), 2) - 1);
  localparam int WP_CYC = umax(umax(ns_to_cyc(T_PULSE_NS, CLK_NS), ns_to_cyc(T_DSETUP_NS, CLK_NS)),
                               umax(ns_to_cyc(T_CYCLE_NS, CLK_NS), 3) - 2);
  localparam int TA_CYC = ns_to_cyc(T_TURN_NS, CLK_NS);

  logic         accept, capture;
  asram_state_e nxt;

  asram_seq #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)) u_seq (
    .clk(clk), .rst(rst), .req(host_req), .req_we(host_we),
    .accept(accept), .nxt(nxt), .capture(capture), .ack(host_ack)
  );

  asram_pins #(.AW(AW), .DW(DW), .LANES(LANES)) u_pins (
    .clk(clk), .rst(rst), .accept(accept), .nxt(nxt), .capture(capture),
    .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .mem_dq_i(mem_dq_i), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bn(mem_bn),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .host_rdata(host_rdata)
  );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
  import asram_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CLK_NS      = 10,
  parameter int T_CYCLE_NS  = 55,
  parameter int T_PULSE_NS  = 45,
  parameter int T_DSETUP_NS = 25,
  parameter int T_TURN_NS   = 25
) (
  input logic          clk,
  input logic          rst,
  input logic          host_ack,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);
  localparam int WP_MIN = umax(umax(ns_to_cyc(T_PULSE_NS, CLK_NS), ns_to_cyc(T_DSETUP_NS, CLK_NS)),
                               umax(ns_to_cyc(T_CYCLE_NS, CLK_NS), 3) - 2);
  localparam int TA_MIN = ns_to_cyc(T_TURN_NS, CLK_NS);

  logic [7:0] wp_run, off_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_run  <= '0;
      off_run <= 8'hFF;
    end else begin
      wp_run  <= !mem_we_n ? ((wp_run == 8'hFF) ? wp_run : wp_run + 1'b1) : 8'h00;
      off_run <= mem_dq_oe ? 8'h00 : ((off_run == 8'hFF) ? off_run : off_run + 1'b1);
    end
  end

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  assert_write_driven_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (wp_run >= 8'(WP_MIN)));

  assert_addr_steady_R4: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && mem_dq_oe));

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> (off_run >= 8'(TA_MIN)));
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .AW(AW), .CLK_NS(CLK_NS), .T_CYCLE_NS(T_CYCLE_NS), .T_PULSE_NS(T_PULSE_NS),
  .T_DSETUP_NS(T_DSETUP_NS), .T_TURN_NS(T_TURN_NS)
) u_chk (
  .clk(clk), .rst(rst), .host_ack(host_ack), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic [1:0]  host_be = '0;
  logic        host_ack;
  logic [15:0] host_rdata, mem_addr, mem_dq_o;
  logic [15:0] mem_dq_i = 16'hEEEE;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_bn;

  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  asram_ctrl u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bn(mem_bn), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // memory model built from the device truth table
  logic [15:0] mdl [logic [15:0]];
  int  wp_run = 0, wp_min = 255, wp_max = 0, gap = 1000, gap_min = 1000;
  int  n_contend = 0, n_addrmove = 0, n_undriven = 0;
  bit  we_low_d = 1'b0, oe_n_d = 1'b1;
  logic [15:0] addr_d = '0;

  function automatic logic [15:0] peek(input logic [15:0] a);
    return mdl.exists(a) ? mdl[a] : 16'hC0DE;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      logic [15:0] cur;
      if (!mem_oe_n && mem_dq_oe) n_contend++;
      if (!mem_we_n && we_low_d && mem_addr != addr_d) n_addrmove++;
      if (!mem_we_n) begin
        wp_run++;
        if (!mem_dq_oe) n_undriven++;
      end else begin
        if (we_low_d) begin
          if (wp_run < wp_min) wp_min = wp_run;
          if (wp_run > wp_max) wp_max = wp_run;
          if (!mem_ce_n) begin
            cur = peek(mem_addr);
            if (!mem_bn[0]) cur[7:0]  = mem_dq_o[7:0];
            if (!mem_bn[1]) cur[15:8] = mem_dq_o[15:8];
            mdl[mem_addr] = cur;
          end
        end
        wp_run = 0;
      end
      if (mem_dq_oe) gap = 0;
      else if (mem_oe_n && gap < 1000) gap++;
      if (!mem_oe_n && oe_n_d && gap < gap_min) gap_min = gap;
      cur = peek(mem_addr);
      if (!mem_ce_n && !mem_oe_n && mem_we_n)
        mem_dq_i = {mem_bn[1] ? 8'hEE : cur[15:8], mem_bn[0] ? 8'hEE : cur[7:0]};
      else
        mem_dq_i = 16'hEEEE;
      we_low_d = !mem_we_n;
      oe_n_d   = mem_oe_n;
      addr_d   = mem_addr;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [15:0] a, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_be = be; host_wdata = wd;
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (host_ack || lat > 60) break;
    end
    rd = host_rdata;
    host_req = 1'b0;
    if (lat > 60) check("R7 request never acknowledged", 32'(lat), 32'd0);
  endtask

  // {we, addr, be, wdata, expected read data}
  localparam int NV = 13;
  localparam logic [50:0] VECS [NV] = '{
    {1'b1, 16'h1234, 2'b11, 16'hA5A5, 16'h0000},
    {1'b0, 16'h1234, 2'b11, 16'h0000, 16'hA5A5},
    {1'b1, 16'h1234, 2'b01, 16'h3C3C, 16'h0000},
    {1'b0, 16'h1234, 2'b11, 16'h0000, 16'hA53C},
    {1'b1, 16'h1234, 2'b10, 16'h7E99, 16'h0000},
    {1'b0, 16'h1234, 2'b01, 16'h0000, 16'h003C},
    {1'b0, 16'h1234, 2'b10, 16'h0000, 16'h7E00},
    {1'b1, 16'hFFFF, 2'b11, 16'hBEEF, 16'h0000},
    {1'b0, 16'hFFFF, 2'b11, 16'h0000, 16'hBEEF},
    {1'b0, 16'h1234, 2'b11, 16'h0000, 16'h7E3C},
    {1'b1, 16'h0000, 2'b00, 16'h1111, 16'h0000},
    {1'b0, 16'h0000, 2'b11, 16'h0000, 16'hC0DE},
    {1'b0, 16'h0000, 2'b00, 16'h0000, 16'h0000}
  };

  initial begin
    logic [15:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset and idle state
    check("R1 reset strobes {ce,oe,we,bn,dq_oe,ack}",
          {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_bn, mem_dq_oe, host_ack},
          {26'd0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0});

    // R5 R2 read latency from idle
    do_req(1'b0, 16'h2222, 2'b11, 16'h0, rd, lat);
    check("R5 read ack latency", 32'(lat), 32'd8);
    check("R2 read of unwritten word", {16'd0, rd}, {16'd0, 16'hC0DE});
    check("R1 idle after ack", {31'd0, mem_ce_n}, 32'd1);

    // R5 R3 write latency from idle (no preceding write)
    do_req(1'b1, 16'h0800, 2'b11, 16'h5A5A, rd, lat);
    check("R5 write ack latency", 32'(lat), 32'd8);

    // vector table: R2 R3 R9
    for (int i = 0; i < NV; i++) begin
      do_req(VECS[i][50], VECS[i][49:34], VECS[i][33:32], VECS[i][31:16], rd, lat);
      if (!VECS[i][50])
        check($sformatf("R2 R9 vector %0d read data", i), {16'd0, rd}, {16'd0, VECS[i][15:0]});
    end

    // R4 host changes after acceptance are ignored
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 16'h4321; host_be = 2'b11; host_wdata = 16'h1111;
    repeat (3) @(negedge clk);
    host_addr = 16'h9999; host_wdata = 16'h2222; host_be = 2'b01;
    lat = 3;
    while (!host_ack && lat < 60) begin @(negedge clk); lat++; end
    host_req = 1'b0;
    do_req(1'b0, 16'h4321, 2'b11, 16'h0, rd, lat);
    check("R4 latched write data", {16'd0, rd}, {16'd0, 16'h1111});
    do_req(1'b0, 16'h9999, 2'b11, 16'h0, rd, lat);
    check("R4 late address not written", {16'd0, rd}, {16'd0, 16'hC0DE});

    repeat (4) @(negedge clk);
    check("R6 no output enable during drive", 32'(n_contend), 32'd0);
    check("R6 turnaround cycles after write", 32'(gap_min), 32'd3);
    check("R4 address moved during write strobe", 32'(n_addrmove), 32'd0);
    check("R3 R8 shortest write strobe", 32'(wp_min), 32'd5);
    check("R3 R8 longest write strobe", 32'(wp_max), 32'd5);
    check("R3 data driven under write strobe", 32'(n_undriven), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL R7 watchdog expired got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule